// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog for a system bus slave. A down-counter of `CNT_W` bits (12 by default) moves by one on every cycle in which the tick-enable input is high. When the count has reached zero and one more tick arrives, the block raises a one-cycle reset request and records the event in a sticky status flag. It then restarts from the programmed reload value.

Software keeps the system alive by writing the control word. The reload bit in that word takes effect only if the upper halfword of the same write holds the fixed key. A write with any other key is thrown away and leaves no trace.

The register file is a small word-addressed map. It holds the reload value, a second mode word, the status flag, a protection word and a clock-selection word. The last two are plain storage here. Reads are combinational and are qualified by the read enable.

Top module: `keyWatchdog`

## Requirements
- R1: After reset, reads return 0x0000_0FFF at offset 0x04, 0x0000_7FFF at offset 0x08, and 0 at offsets 0x0C, 0x10 and 0x18. The reset-request output is low.
- R2: A write to offset 0x00 whose bits [31:16] equal 0x5FA0 and whose bit 0 is 1 loads the counter with the reload value. This reload wins over a tick in the same cycle, and no underflow happens in that cycle.
- R3: A write to offset 0x00 with any other value in bits [31:16] changes no state at all: the count, the flag and the registers are untouched. The same holds for the correct key with bit 0 at 0.
- R4: A read of offset 0x00, of a misaligned address or of an unmapped offset (such as 0x14 or 0x1C) returns 0. The reload bit therefore always reads back as 0.
- R5: The count drops by one on each cycle with the tick enable high and holds when it is low.
- R6: A tick that arrives while the count is zero is an underflow. On the next cycle the reset-request output is high for exactly that one cycle, status bit 0 is set, and the count restarts from the reload value. A reload value of N therefore gives an underflow on the (N+1)th tick.
- R7: A read of offset 0x0C returns the flag in bit 0 and clears it. If an underflow happens in the same cycle as the read, the flag stays set.
- R8: Offset 0x04 keeps only bits [11:0], and its upper bits read as 0. Offsets 0x08, 0x10 and 0x18 are full 32-bit read/write words. Writes to offset 0x0C are ignored.
- R9: Leaving reset, the counter holds the reset reload value 0xFFF, so the first underflow comes on the 4096th tick.
- R10: Writing the reload register does not disturb a running count. The new value is used only from the next reload or underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Counting enable; one count per high cycle |
| addr | input | ADDR_W | Byte offset of the register access |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe; clears the flag on status reads |
| rdData | output | 32 | Read data, combinational, 0 when rdEn is low |
| rstReq | output | 1 | One-cycle reset request on underflow |

## Verification
The bench targets keys that differ from the valid one by a single bit, by a swapped byte order, or by a cleared request bit. A design that compared only part of the key, or that ignored the request bit, would reload and hide an underflow that should fire. It also aims a reload and a status read at the exact cycle of an underflow. A wrong priority would then show as a missing or spurious reset pulse, or as a lost flag. A reload value of zero and a long run from the reset value probe off-by-one errors in when the underflow fires. Writes to the reload register while the counter is running catch a design that loads the new value at once.

// File: rtl/kwdtPkg.sv
package kwdtPkg;

  localparam int unsigned OFF_CTRL   = 'h00;
  localparam int unsigned OFF_CFG    = 'h04;
  localparam int unsigned OFF_MODEB  = 'h08;
  localparam int unsigned OFF_STATUS = 'h0C;
  localparam int unsigned OFF_PROT   = 'h10;
  localparam int unsigned OFF_CLKSEL = 'h18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_MODEB,
    SEL_STATUS,
    SEL_PROT,
    SEL_CLKSEL
  } regSelE;

  typedef struct packed {
    logic   reloadStb;
    logic   cfgWr;
    logic   modeBWr;
    logic   protWr;
    logic   clkWr;
    logic   statusRd;
    regSelE rdSel;
  } dpStrobesT;

endpackage

// File: rtl/kwdtCtrl.sv
module kwdtCtrl
  import kwdtPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int KEY_W  = 16,
  parameter logic [KEY_W-1:0] RELOAD_KEY = 16'h5FA0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [KEY_W-1:0]  keyField,
  input  logic              reloadBit,
  output dpStrobesT         strb
);

  regSelE sel;
  logic   isCtrl;
  logic   keyOk;

  // Address decode; anything not listed (including misaligned) is unmapped.
  always_comb begin
    sel    = SEL_NONE;
    isCtrl = 1'b0;
    if (addr == ADDR_W'(OFF_CTRL))        isCtrl = 1'b1;
    else if (addr == ADDR_W'(OFF_CFG))    sel = SEL_CFG;
    else if (addr == ADDR_W'(OFF_MODEB))  sel = SEL_MODEB;
    else if (addr == ADDR_W'(OFF_STATUS)) sel = SEL_STATUS;
    else if (addr == ADDR_W'(OFF_PROT))   sel = SEL_PROT;
    else if (addr == ADDR_W'(OFF_CLKSEL)) sel = SEL_CLKSEL;
  end

  assign keyOk = (keyField == RELOAD_KEY);

  // The reload bit is a strobe: it lives for the write cycle only and
  // never holds state, so it always reads back as zero.
  always_comb begin
    strb.reloadStb = wrEn && isCtrl && keyOk && reloadBit;
    strb.cfgWr     = wrEn && (sel == SEL_CFG);
    strb.modeBWr   = wrEn && (sel == SEL_MODEB);
    strb.protWr    = wrEn && (sel == SEL_PROT);
    strb.clkWr     = wrEn && (sel == SEL_CLKSEL);
    strb.statusRd  = rdEn && (sel == SEL_STATUS);
    strb.rdSel     = rdEn ? sel : SEL_NONE;
  end

  // R8: at most one register is written per access
  a_r8_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.reloadStb, strb.cfgWr, strb.modeBWr, strb.protWr, strb.clkWr}));

  // R3: a reload strobe never comes without a write
  a_r3_reload_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.reloadStb |-> wrEn);

endmodule

// File: rtl/kwdtDatapath.sv
module kwdtDatapath
  import kwdtPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  parameter logic [CNT_W-1:0]  CFG_RST   = 12'hFFF,
  parameter logic [DATA_W-1:0] MODEB_RST = 32'h0000_7FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [DATA_W-1:0] wrData,
  input  dpStrobesT         strb,
  output logic [DATA_W-1:0] rdData,
  output logic              rstReq
);

  localparam int PAD_CFG = DATA_W - CNT_W;

  logic [CNT_W-1:0]  cfgVal;
  logic [DATA_W-1:0] modeBVal;
  logic [DATA_W-1:0] protVal;
  logic [DATA_W-1:0] clkVal;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  countNext;
  logic              uflFlag;
  logic              uflEvent;
  logic              rstReqQ;

  // Plain storage registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgVal   <= CFG_RST;
      modeBVal <= MODEB_RST;
      protVal  <= '0;
      clkVal   <= '0;
    end else begin
      if (strb.cfgWr)   cfgVal   <= wrData[CNT_W-1:0];
      if (strb.modeBWr) modeBVal <= wrData;
      if (strb.protWr)  protVal  <= wrData;
      if (strb.clkWr)   clkVal   <= wrData;
    end
  end

  // Counter: reload beats tick; a tick at zero is the underflow
  always_comb begin
    uflEvent = tickEn && !strb.reloadStb && (count == '0);
    if (strb.reloadStb)   countNext = cfgVal;
    else if (uflEvent)    countNext = cfgVal;
    else if (tickEn)      countNext = count - CNT_W'(1);
    else                  countNext = count;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= CFG_RST;
      uflFlag <= 1'b0;
      rstReqQ <= 1'b0;
    end else begin
      count   <= countNext;
      rstReqQ <= uflEvent;
      if (uflEvent)           uflFlag <= 1'b1;
      else if (strb.statusRd) uflFlag <= 1'b0;
    end
  end

  assign rstReq = rstReqQ;

  // Read mux
  always_comb begin
    unique case (strb.rdSel)
      SEL_CFG:    rdData = {{PAD_CFG{1'b0}}, cfgVal};
      SEL_MODEB:  rdData = modeBVal;
      SEL_STATUS: rdData = {{(DATA_W-1){1'b0}}, uflFlag};
      SEL_PROT:   rdData = protVal;
      SEL_CLKSEL: rdData = clkVal;
      default:    rdData = '0;
    endcase
  end

  // R2: a valid reload lands the stored reload value
  a_r2_reload_value: assert property (@(posedge clk) disable iff (!rstN)
    strb.reloadStb |=> count == $past(cfgVal));

  // R5: one step down per tick away from zero
  a_r5_step_down: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !strb.reloadStb && count != '0) |=> count == $past(count) - CNT_W'(1));

  // R5: no tick, no reload, no movement
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strb.reloadStb) |=> $stable(count));

  // R6: a reset request is always recorded in the flag
  a_r6_req_flag: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> uflFlag);

  // R6: after an underflow the counter restarts from the reload value
  a_r6_restart: assert property (@(posedge clk) disable iff (!rstN)
    uflEvent |=> count == $past(cfgVal));

  // R7: a status read without a colliding underflow clears the flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statusRd && !uflEvent) |=> !uflFlag);

endmodule

// File: rtl/keyWatchdog.sv
module keyWatchdog
  import kwdtPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 12,
  parameter logic [15:0] RELOAD_KEY = 16'h5FA0,
  parameter logic [CNT_W-1:0] CFG_RST = 12'hFFF,
  parameter logic [31:0] MODEB_RST = 32'h0000_7FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  output logic [31:0]       rdData,
  output logic              rstReq
);

  localparam int DATA_W = 32;
  localparam int KEY_W  = DATA_W / 2;

  dpStrobesT strb;

  kwdtCtrl #(
    .ADDR_W    (ADDR_W),
    .KEY_W     (KEY_W),
    .RELOAD_KEY(RELOAD_KEY)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .keyField (wrData[DATA_W-1:KEY_W]),
    .reloadBit(wrData[0]),
    .strb     (strb)
  );

  kwdtDatapath #(
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .CFG_RST  (CFG_RST),
    .MODEB_RST(MODEB_RST)
  ) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .tickEn(tickEn),
    .wrData(wrData),
    .strb  (strb),
    .rdData(rdData),
    .rstReq(rstReq)
  );

  // R4: the control word is write-only
  a_r4_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(OFF_CTRL)) |-> rdData == '0);

  // R4: nothing drives the read bus when no read is requested
  a_r4_idle_bus: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == '0);

endmodule

// File: tb/tb_keyWatchdog.sv
module tb_keyWatchdog;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        rstReq;

  int nChecks = 0;
  int nFails  = 0;

  // model state
  logic [11:0] mCount = 12'hFFF;
  logic [11:0] mCfg   = 12'hFFF;
  logic [31:0] mModeB = 32'h0000_7FFF;
  logic [31:0] mProt  = '0;
  logic [31:0] mClk   = '0;
  logic        mFlag  = 1'b0;
  logic        mReq   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  keyWatchdog dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .rstReq(rstReq)
  );

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h04:   return {20'b0, mCfg};
      8'h08:   return mModeB;
      8'h0C:   return {31'b0, mFlag};
      8'h10:   return mProt;
      8'h18:   return mClk;
      default: return 32'b0;
    endcase
  endfunction

  function automatic logic validReload(input logic w, input logic [7:0] a, input logic [31:0] d);
    return w && a == 8'h00 && d[31:16] == 16'h5FA0 && d[0];
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic t, input logic w, input logic r,
                      input logic [7:0] a, input logic [31:0] d);
    logic        rel, ufl;
    logic [11:0] nCount;
    @(negedge clk);
    tickEn = t; wrEn = w; rdEn = r; addr = a; wrData = d;
    #2;
    if (r) check(tag, "rdData", rdData, expRead(a));
    rel = validReload(w, a, d);
    ufl = t && !rel && mCount == 12'd0;
    if (rel || ufl) nCount = mCfg;
    else if (t)     nCount = mCount - 12'd1;
    else            nCount = mCount;
    @(posedge clk);
    mCount = nCount;
    mReq   = ufl;
    if (ufl) mFlag = 1'b1;
    else if (r && a == 8'h0C) mFlag = 1'b0;
    if (w && a == 8'h04) mCfg   = d[11:0];
    if (w && a == 8'h08) mModeB = d;
    if (w && a == 8'h10) mProt  = d;
    if (w && a == 8'h18) mClk   = d;
    #2;
    check({"R6 during ", tag}, "rstReq", {31'b0, rstReq}, {31'b0, mReq});
  endtask

  task automatic idle(input string tag, input int n, input logic t);
    for (int i = 0; i < n; i++) step(tag, t, 1'b0, 1'b0, 8'h00, 32'h0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: run not complete (actual timeout, expected finish)");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #3 rstN = 1'b1;

    // R1: reset values
    check("R1", "rstReq", {31'b0, rstReq}, 32'h0);
    step("R1", 0, 0, 1, 8'h04, 0);
    step("R1", 0, 0, 1, 8'h08, 0);
    step("R1", 0, 0, 1, 8'h0C, 0);
    step("R1", 0, 0, 1, 8'h10, 0);
    step("R1", 0, 0, 1, 8'h18, 0);

    // R4: write-only control word, unmapped and misaligned offsets
    step("R4", 0, 0, 1, 8'h00, 0);
    step("R4", 0, 0, 1, 8'h14, 0);
    step("R4", 0, 0, 1, 8'h1C, 0);
    step("R4", 0, 0, 1, 8'h05, 0);
    step("R4", 0, 0, 1, 8'hFC, 0);

    // R9: first underflow only on the 4096th tick from reset
    idle("R9", 4095, 1'b1);
    step("R9", 1, 0, 0, 8'h00, 0);
    step("R7", 0, 0, 1, 8'h0C, 0);  // flag set, cleared by this read
    step("R7", 0, 0, 1, 8'h0C, 0);  // now reads zero

    // R8: register access
    step("R8", 0, 1, 0, 8'h04, 32'hABCD_E005);
    step("R8", 0, 0, 1, 8'h04, 0);
    step("R8", 0, 1, 0, 8'h08, 32'h1234_5678);
    step("R8", 0, 0, 1, 8'h08, 0);
    step("R8", 0, 1, 0, 8'h10, 32'hDEAD_BEEF);
    step("R8", 0, 0, 1, 8'h10, 0);
    step("R8", 0, 1, 0, 8'h18, 32'h0000_0003);
    step("R8", 0, 0, 1, 8'h18, 0);
    step("R8", 0, 1, 0, 8'h0C, 32'hFFFF_FFFF);
    step("R8", 0, 0, 1, 8'h0C, 0);

    // R2/R10: reload to 5, then change the reload value mid-count
    step("R2", 0, 1, 0, 8'h00, 32'h5FA0_0001);
    step("R10", 1, 1, 0, 8'h04, 32'h0000_0002);
    idle("R10", 6, 1'b1);  // underflow on the 6th tick of the count of 5
    idle("R10", 4, 1'b1);  // restart from 2: next underflow 3 ticks later
    step("R10", 0, 0, 1, 8'h04, 0);

    // R5: gaps in ticking
    step("R5", 0, 1, 0, 8'h00, 32'h5FA0_0001);
    idle("R5", 20, 1'b0);
    for (int i = 0; i < 12; i++) step("R5", i[0], 1'b0, 1'b0, 8'h00, 32'h0);

    // R2: reload collides with a tick at zero
    step("R2", 0, 1, 0, 8'h04, 32'h0000_0001);
    step("R2", 0, 1, 0, 8'h00, 32'h5FA0_0001);
    step("R2", 1, 0, 0, 8'h00, 0);
    step("R2", 1, 1, 0, 8'h00, 32'h5FA0_0001);
    step("R2", 0, 0, 1, 8'h0C, 0);

    // R3: bad keys at zero do not save the counter
    step("R3", 1, 1, 0, 8'h00, 32'h5FA0_0001);
    step("R3", 1, 0, 0, 8'h00, 0);
    step("R3", 1, 1, 0, 8'h00, 32'h5FA1_0001);
    step("R3", 1, 1, 0, 8'h00, 32'hA05F_0001);
    step("R3", 1, 1, 0, 8'h00, 32'h0000_0001);
    step("R3", 1, 1, 0, 8'h00, 32'h5FA0_0000);
    step("R3", 0, 1, 0, 8'h00, 32'h7FA0_0001);
    step("R3", 0, 0, 1, 8'h0C, 0);
    step("R3", 0, 0, 1, 8'h04, 0);

    // R6/R7: reload value zero fires on every tick; read collides with underflow
    step("R6", 0, 1, 0, 8'h04, 32'h0);
    step("R6", 0, 1, 0, 8'h00, 32'h5FA0_0001);
    idle("R6", 3, 1'b1);
    step("R7", 1, 0, 1, 8'h0C, 0);
    step("R7", 0, 0, 1, 8'h0C, 0);
    step("R7", 0, 0, 1, 8'h0C, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic        t, w, r;
      logic [7:0]  a;
      logic [31:0] d;
      int          op;
      t  = $urandom_range(0, 1);
      op = $urandom_range(0, 99);
      w = 1'b0; r = 1'b0; a = 8'h00; d = $urandom();
      if (op < 10) begin
        w = 1'b1; a = 8'h00; d = {16'h5FA0, d[15:1], 1'b1};
      end else if (op < 16) begin
        w = 1'b1; a = 8'h00; d = {16'h5FA0 ^ (16'h1 << $urandom_range(0, 15)), d[15:1], 1'b1};
      end else if (op < 24) begin
        w = 1'b1; a = 8'h04; d = {d[31:4], 4'($urandom_range(0, 9))};
      end else if (op < 30) begin
        w = 1'b1; a = 8'(4 * $urandom_range(0, 7));
        if (a == 8'h00 || a == 8'h04) a = 8'h10;
      end else if (op < 60) begin
        r = 1'b1; a = 8'(4 * $urandom_range(0, 7));
      end else if (op < 63) begin
        r = 1'b1; a = 8'($urandom_range(0, 255));
      end
      step("RND", t, w, r, a, d);
    end

    summary();
  end

endmodule